// File: doc/BRIEF.md
# Address Computation Adder

This block is the 16-bit address path of a small 8-bit processor. It adds a left operand, taken from one of the five 16-bit pointer registers, to a right operand that is assembled byte by byte from the 8-bit working registers or from a small signed constant. A separate increment bit adds one more. The same sum drives the memory address bus and the write-back value for any pointer register whose save strobe is raised.

Every opcode that steps the instruction pointer, reaches the stack with an offset, pops, or walks a pointer forward gets its address here. The block has no internal state: the pointer registers sit outside it. For each register it returns the value that register should hold after the current cycle.

Top module: `addr_calc_adder`

## Requirements
- R1: `lsel` picks the left operand. Bit 0 selects I, bit 1 V, bit 2 S, bit 3 P and bit 4 Q. When `lsel` is zero the left operand is zero.
- R2: `rsel` bit 0 places U in the high byte and bit 1 places C there. Bit 2 places T in the low byte and bit 3 places B there. Unselected bytes read as zero, so {U,T}, {C,B} and mixed pairs can be formed.
- R3: `rsel` bit 4 adds T and bit 5 adds B as a signed 8-bit offset, sign-extended to 16 bits.
- R4: `rsel` bits 6, 7, 8 and 9 add the constants +1, +2, -1 and -2.
- R5: `inc` adds one on top of the selected operands.
- R6: The sum wraps modulo 65536, and no flags are produced.
- R7: For each register, the matching `save` bit (same bit order as `lsel`) makes its next value the sum. A register whose bit is clear keeps its current value.
- R8: When several `rsel` bits are raised together, their 16-bit operand values are combined by bitwise OR before the addition.
- R9: `addr` always carries the sum, whether or not any save strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_reg | input | 16 | Instruction pointer value |
| v_reg | input | 16 | Interrupt vector value |
| s_reg | input | 16 | Stack pointer value |
| p_reg | input | 16 | Pointer P value |
| q_reg | input | 16 | Pointer Q value |
| u_reg | input | 8 | Byte register U (high-byte source) |
| c_reg | input | 8 | Byte register C (high-byte source) |
| t_reg | input | 8 | Byte register T (low-byte or offset source) |
| b_reg | input | 8 | Byte register B (low-byte or offset source) |
| lsel | input | 5 | One-hot left operand select |
| rsel | input | 10 | Right operand source selects |
| inc | input | 1 | Add-one strobe |
| save | input | 5 | Per-register save strobes |
| addr | output | 16 | Sum, driven to the address bus |
| nxt_i | output | 16 | Next value of I |
| nxt_v | output | 16 | Next value of V |
| nxt_s | output | 16 | Next value of S |
| nxt_p | output | 16 | Next value of P |
| nxt_q | output | 16 | Next value of Q |

## Verification
The increment strobe and a constant or register-pair right operand are often active in the same cycle. One case is the second byte of a 16-bit access, where {U,T} plus one is needed. Another is a pointer stepped by +1 that also gets the extra one. The bench applies both at once in its vector table and compares the result against a sum worked out by hand. It also raises save strobes in the same cycles, to confirm that the address and the write-back value agree and that registers without a strobe keep their values.

// File: rtl/addr_add_pkg.sv
package addr_add_pkg;
   // Pointer register order; bit positions of lsel and save follow it.
   localparam int PTR_I   = 0;
   localparam int PTR_V   = 1;
   localparam int PTR_S   = 2;
   localparam int PTR_P   = 3;
   localparam int PTR_Q   = 4;
   localparam int NUM_PTR = 5;

   // Right operand source order; bit positions of rsel follow it.
   localparam int RS_HI_U   = 0;
   localparam int RS_HI_C   = 1;
   localparam int RS_LO_T   = 2;
   localparam int RS_LO_B   = 3;
   localparam int RS_SX_T   = 4;
   localparam int RS_SX_B   = 5;
   localparam int RS_P1     = 6;
   localparam int RS_P2     = 7;
   localparam int RS_M1     = 8;
   localparam int RS_M2     = 9;
   localparam int NUM_RSEL  = 10;
endpackage

// File: rtl/addr_left_mux.sv
module addr_left_mux #(
   parameter int AW = 16,
   parameter int N  = 5
) (
   input  logic [N-1:0][AW-1:0] regs,
   input  logic [N-1:0]         sel,
   output logic [AW-1:0]        opnd
);
   always_comb begin
      opnd = '0;
      for (int j = 0; j < N; j++) begin
         if (sel[j]) opnd = opnd | regs[j];
      end
   end

   // R1: no select means a zero left operand
   always_comb begin
      if (!$isunknown(sel) && !$isunknown(opnd) && sel == '0)
         p_left_none_r1 : assert (opnd == '0);
   end
endmodule

// File: rtl/addr_right_build.sv
module addr_right_build
   import addr_add_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW/2-1:0]     hi_u,
   input  logic [AW/2-1:0]     hi_c,
   input  logic [AW/2-1:0]     lo_t,
   input  logic [AW/2-1:0]     lo_b,
   input  logic [NUM_RSEL-1:0] rsel,
   output logic [AW-1:0]       opnd
);
   localparam int BW = AW / 2;

   logic [NUM_RSEL-1:0][AW-1:0] term;
   logic [1:0][BW-1:0]          offs;

   assign offs[0] = lo_t;
   assign offs[1] = lo_b;

   always_comb begin
      term[RS_HI_U] = {hi_u, {BW{1'b0}}};
      term[RS_HI_C] = {hi_c, {BW{1'b0}}};
      term[RS_LO_T] = {{BW{1'b0}}, lo_t};
      term[RS_LO_B] = {{BW{1'b0}}, lo_b};
      term[RS_P1]   = AW'(1);
      term[RS_P2]   = AW'(2);
      term[RS_M1]   = {AW{1'b1}};
      term[RS_M2]   = ~AW'(1);
   end

   // the two signed offsets share one extension shape
   for (genvar g = 0; g < 2; g++) begin : g_sext
      assign term[RS_SX_T + g] = {{BW{offs[g][BW-1]}}, offs[g]};
   end

   always_comb begin
      opnd = '0;
      for (int j = 0; j < NUM_RSEL; j++) begin
         if (rsel[j]) opnd = opnd | term[j];
      end
   end

   // R2: a high-byte-only source leaves the low byte empty
   always_comb begin
      if (!$isunknown(rsel) && !$isunknown(opnd) &&
          (rsel == (NUM_RSEL'(1) << RS_HI_U) || rsel == (NUM_RSEL'(1) << RS_HI_C)))
         p_hi_only_r2 : assert (opnd[BW-1:0] == '0);
   end
endmodule

// File: rtl/addr_sum.sv
module addr_sum #(
   parameter int AW        = 16,
   parameter int INC_STYLE = 0
) (
   input  logic [AW-1:0] left,
   input  logic [AW-1:0] right,
   input  logic          inc,
   output logic [AW-1:0] sum
);
   if (INC_STYLE > 1) begin : g_bad_style
      $error("addr_sum: INC_STYLE must be 0 or 1");
   end

   if (INC_STYLE == 0) begin : g_direct
      assign sum = left + right + {{(AW-1){1'b0}}, inc};
   end else begin : g_carry
      // inc rides in as carry-in of a single AW+1 wide adder
      logic [AW:0] wide;
      assign wide = {left, 1'b1} + {right, inc};
      assign sum  = wide[AW:1];
   end

   // R6: all-ones plus the increment wraps to zero
   always_comb begin
      if (!$isunknown({left, right, inc, sum}) &&
          left == '1 && right == '0 && inc)
         p_wrap_r6 : assert (sum == '0);
   end
endmodule

// File: rtl/addr_writeback.sv
module addr_writeback #(
   parameter int AW = 16,
   parameter int N  = 5
) (
   input  logic [N-1:0][AW-1:0] regs,
   input  logic [N-1:0]         save,
   input  logic [AW-1:0]        sum,
   output logic [N-1:0][AW-1:0] nxt
);
   for (genvar g = 0; g < N; g++) begin : g_reg
      assign nxt[g] = save[g] ? sum : regs[g];
   end

   // R7: a register without its strobe keeps its value
   always_comb begin
      for (int j = 0; j < N; j++) begin
         if (!$isunknown({save, regs, nxt}) && !save[j])
            p_hold_r7 : assert (nxt[j] == regs[j]);
      end
   end
endmodule

// File: rtl/addr_calc_adder.sv
module addr_calc_adder
   import addr_add_pkg::*;
#(
   parameter int AW        = 16,
   parameter int INC_STYLE = 0
) (
   input  logic [AW-1:0]       i_reg,
   input  logic [AW-1:0]       v_reg,
   input  logic [AW-1:0]       s_reg,
   input  logic [AW-1:0]       p_reg,
   input  logic [AW-1:0]       q_reg,
   input  logic [AW/2-1:0]     u_reg,
   input  logic [AW/2-1:0]     c_reg,
   input  logic [AW/2-1:0]     t_reg,
   input  logic [AW/2-1:0]     b_reg,
   input  logic [NUM_PTR-1:0]  lsel,
   input  logic [NUM_RSEL-1:0] rsel,
   input  logic                inc,
   input  logic [NUM_PTR-1:0]  save,
   output logic [AW-1:0]       addr,
   output logic [AW-1:0]       nxt_i,
   output logic [AW-1:0]       nxt_v,
   output logic [AW-1:0]       nxt_s,
   output logic [AW-1:0]       nxt_p,
   output logic [AW-1:0]       nxt_q
);
   if (AW < 4 || (AW % 2) != 0) begin : g_bad_width
      $error("addr_calc_adder: AW must be even and at least 4");
   end

   logic [NUM_PTR-1:0][AW-1:0] regs;
   logic [NUM_PTR-1:0][AW-1:0] nxt;
   logic [AW-1:0]              left_op;
   logic [AW-1:0]              right_op;

   always_comb begin
      regs[PTR_I] = i_reg;
      regs[PTR_V] = v_reg;
      regs[PTR_S] = s_reg;
      regs[PTR_P] = p_reg;
      regs[PTR_Q] = q_reg;
   end

   addr_left_mux #(.AW(AW), .N(NUM_PTR)) u_left (
      .regs (regs),
      .sel  (lsel),
      .opnd (left_op)
   );

   addr_right_build #(.AW(AW)) u_right (
      .hi_u (u_reg),
      .hi_c (c_reg),
      .lo_t (t_reg),
      .lo_b (b_reg),
      .rsel (rsel),
      .opnd (right_op)
   );

   addr_sum #(.AW(AW), .INC_STYLE(INC_STYLE)) u_sum (
      .left  (left_op),
      .right (right_op),
      .inc   (inc),
      .sum   (addr)
   );

   addr_writeback #(.AW(AW), .N(NUM_PTR)) u_wb (
      .regs (regs),
      .save (save),
      .sum  (addr),
      .nxt  (nxt)
   );

   assign nxt_i = nxt[PTR_I];
   assign nxt_v = nxt[PTR_V];
   assign nxt_s = nxt[PTR_S];
   assign nxt_p = nxt[PTR_P];
   assign nxt_q = nxt[PTR_Q];

   // R1 and R5: with no operand at all, the address is the increment alone
   always_comb begin
      if (!$isunknown({lsel, rsel, inc, addr}) && lsel == '0 && rsel == '0)
         p_idle_r1 : assert (addr == {{(AW-1){1'b0}}, inc});
   end

   // R9: a saved register receives exactly the bus address
   always_comb begin
      if (!$isunknown({save, addr, nxt_s}) && save[PTR_S])
         p_save_bus_r9 : assert (nxt_s == addr);
   end
endmodule

// File: tb/tb_addr_calc_adder.sv
module tb_addr_calc_adder;
   localparam int NV = 15;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        rst_n;
   logic [15:0] regv [5];
   logic [7:0]  u_reg, c_reg, t_reg, b_reg;
   logic [4:0]  lsel, save;
   logic [9:0]  rsel;
   logic        inc;
   logic [15:0] addr, nxt_i, nxt_v, nxt_s, nxt_p, nxt_q;
   logic [15:0] e;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   addr_calc_adder dut (
      .i_reg(regv[0]), .v_reg(regv[1]), .s_reg(regv[2]), .p_reg(regv[3]), .q_reg(regv[4]),
      .u_reg(u_reg), .c_reg(c_reg), .t_reg(t_reg), .b_reg(b_reg),
      .lsel(lsel), .rsel(rsel), .inc(inc), .save(save),
      .addr(addr), .nxt_i(nxt_i), .nxt_v(nxt_v), .nxt_s(nxt_s),
      .nxt_p(nxt_p), .nxt_q(nxt_q)
   );

   // {lsel, rsel, inc, save, expected addr}
   localparam logic [36:0] VEC [NV] = '{
      {5'b00001, 10'h000, 1'b1, 5'b00001, 16'h1235},   // R1 R5 R7
      {5'b00100, 10'h010, 1'b0, 5'b00100, 16'h0080},   // R3 negative T
      {5'b01000, 10'h020, 1'b0, 5'b01000, 16'h417E},   // R3 positive B
      {5'b00100, 10'h100, 1'b0, 5'b00000, 16'h00FF},   // R4 minus one
      {5'b10000, 10'h080, 1'b0, 5'b10000, 16'h0001},   // R4 R6 plus two wraps
      {5'b00000, 10'h005, 1'b0, 5'b00000, 16'h5A80},   // R2 {U,T}
      {5'b00000, 10'h00A, 1'b0, 5'b00000, 16'h127F},   // R2 {C,B}
      {5'b00000, 10'h005, 1'b1, 5'b00000, 16'h5A81},   // R2 R5 second byte
      {5'b00010, 10'h200, 1'b0, 5'b00010, 16'h7FFE},   // R4 minus two
      {5'b01000, 10'h040, 1'b1, 5'b00000, 16'h4101},   // R4 R5 plus one plus inc
      {5'b10000, 10'h000, 1'b1, 5'b00000, 16'h0000},   // R6 wrap
      {5'b00000, 10'h000, 1'b0, 5'b00000, 16'h0000},   // R1 nothing selected
      {5'b00001, 10'h009, 1'b0, 5'b00000, 16'h6CB3},   // R2 {U,B} plus I
      {5'b00000, 10'h00C, 1'b0, 5'b00000, 16'h00FF},   // R8 T|B
      {5'b00000, 10'h050, 1'b0, 5'b00000, 16'hFF81}    // R8 sext T | +1
   };

   function automatic string vec_tag(int k);
      case (k)
         0: return "R5";   1: return "R3";   2: return "R3";
         3: return "R4";   4: return "R6";   5: return "R2";
         6: return "R2";   7: return "R5";   8: return "R4";
         9: return "R4";  10: return "R6";  11: return "R1";
        12: return "R2";  13: return "R8";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_saves(string tag, logic [15:0] sum);
      chk({tag, " R7 nxt_i"}, nxt_i, save[0] ? sum : regv[0]);
      chk({tag, " R7 nxt_v"}, nxt_v, save[1] ? sum : regv[1]);
      chk({tag, " R7 nxt_s"}, nxt_s, save[2] ? sum : regv[2]);
      chk({tag, " R7 nxt_p"}, nxt_p, save[3] ? sum : regv[3]);
      chk({tag, " R7 nxt_q"}, nxt_q, save[4] ? sum : regv[4]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      regv[0] = 16'h1234; regv[1] = 16'h8000; regv[2] = 16'h0100;
      regv[3] = 16'h40FF; regv[4] = 16'hFFFF;
      u_reg = 8'h5A; c_reg = 8'h12; t_reg = 8'h80; b_reg = 8'h7F;
      lsel = '0; rsel = '0; inc = 1'b0; save = '0;
      rst_n = 1'b0;

      // reset: all strobes idle
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset addr", addr, 16'h0000);
      chk_saves("reset", 16'h0000);
      @(posedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(posedge clk);
         {lsel, rsel, inc, save, e} = VEC[k];
         @(negedge clk);
         chk({vec_tag(k), " vector addr"}, addr, e);
         chk_saves(vec_tag(k), e);
      end

      // R1: each left register alone
      for (int j = 0; j < 5; j++) begin
         @(posedge clk);
         lsel = 5'(1 << j); rsel = '0; inc = 1'b0; save = '0;
         @(negedge clk);
         chk("R1 single left", addr, regv[j]);
      end

      // R9: address identical with and without a save strobe
      @(posedge clk);
      lsel = 5'b01000; rsel = 10'h100; inc = 1'b0; save = '0;
      @(negedge clk);
      chk("R9 no save", addr, 16'h40FE);
      @(posedge clk);
      save = 5'b01000;
      @(negedge clk);
      chk("R9 with save", addr, 16'h40FE);
      chk("R9 nxt_p", nxt_p, 16'h40FE);

      // R3: small positive offset on S
      @(posedge clk);
      t_reg = 8'h01; lsel = 5'b00100; rsel = 10'h010; save = '0;
      @(negedge clk);
      chk("R3 sext small", addr, 16'h0101);

      // R8: high-byte OR of U and C
      @(posedge clk);
      lsel = '0; rsel = 10'h003;
      @(negedge clk);
      chk("R8 U|C", addr, 16'h5A00);

      finish_run();
   end
endmodule